// File: doc/BRIEF.md
# Clock Loop Lock Indicator with Missing-Feedback Watchdog

This block produces a digital lock flag for a clock-generation loop. A reference clock and the loop's feedback clock arrive as asynchronous signals; both are synchronized into a fast system clock domain, and their rising edges are compared there. The separation between edges is measured in system clock ticks. A feedback edge is judged good when a reference rising edge lies within a programmable number of ticks of it, on either side. Otherwise it is judged a phase error.

The judgements drive a two-state acquire/locked machine with asymmetric hysteresis. Acquiring needs a long run of clean feedback edges; dropping out needs a short run of erroneous ones. A separate watchdog protects the locked state against a feedback clock that simply stops, which would otherwise produce no judgements at all. It counts a divided-down version of the reference and drops the flag once a programmable number of those slow ticks pass without any feedback edge. The flag is only meaningful while the reference itself is toggling.

Top module: `pll_lock_detect`

## Requirements
- R1: While `rst` is high and on the first cycles after it, `lock` is low, and both the clean-run and the error-run counts are zero.
- R2: Each synchronized feedback rising edge is judged against the nearest synchronized reference rising edge, before or after it. If that distance in `clk` ticks is at most `phase_window`, the edge is clean. If it is larger, the edge is a phase error. A distance exactly equal to the window is clean.
- R3: While acquiring, `lock` rises only after GAIN_CYCLES (default 32) consecutive clean feedback edges; after 31 it is still low.
- R4: A phase error while acquiring restarts the clean-run count from zero.
- R5: While locked, DROP_CYCLES (default 4) consecutive phase errors make `lock` fall; after 3 it is still high.
- R6: A clean feedback edge while locked clears the error-run count, so the errors that lead to a drop must all be consecutive.
- R7: A divided tick occurs on every REF_DIV-th (default 8) reference rising edge counted since the last feedback edge. While locked, once `wd_ticks` divided ticks pass with no feedback edge, `lock` falls. With REF_DIV 8 and `wd_ticks` 3, it is still high after 23 reference edges and low after the 24th.
- R8: Every feedback rising edge restarts the watchdog, so a feedback clock that keeps running never trips it, however long it runs.
- R9: `lock` changes only on the cycle after a phase judgement or a watchdog expiry.
- R10: Both clock inputs pass through SYNC_STAGES flip-flops before edge detection, so reference and feedback see equal latency and the measured distance is unbiased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples both input clocks |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Reference clock, asynchronous to `clk` |
| fb_clk_in | input | 1 | Feedback clock, asynchronous to `clk` |
| phase_window | input | WIN_W | Largest allowed edge distance in `clk` ticks |
| wd_ticks | input | WD_W | Watchdog timeout in divided-reference ticks |
| lock | output | 1 | High when locked, low while acquiring |

## Verification
The embedded properties check on every cycle how `lock` may move. It can only rise right after a clean judgement, and only fall right after an error judgement or a watchdog expiry. It holds still otherwise. An error judgement never directly follows a reference edge, and the watchdog only expires while locked. The exact run lengths (31 versus 32 clean edges, 3 versus 4 errors), the window boundary on both sides of the reference, and the exact watchdog edge count are visible only through the bench's timed scenarios. The same holds for the restart of each run by an opposite judgement.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic {
    ST_ACQUIRE = 1'b0,
    ST_LOCKED  = 1'b1
  } lock_state_e;

  // One judgement per feedback edge.
  typedef struct packed {
    logic valid;
    logic err;
  } verdict_t;
endpackage

// File: rtl/lk_edge_sync.sv
module lk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/lk_phase_meter.sv
module lk_phase_meter
  import pll_lock_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_rise,
  input  logic             fb_rise,
  input  logic [WIN_W-1:0] window,
  output verdict_t         verdict
);
  localparam logic [WIN_W-1:0] SAT = '1;

  logic [WIN_W-1:0] since_ref_q, since_now;
  logic [WIN_W-1:0] wait_q, wait_d;
  logic             pend_q, pend_d;
  verdict_t         v_d;

  // Distance back to the latest reference edge (0 when coincident).
  assign since_now = ref_rise ? '0 : since_ref_q;

  always_ff @(posedge clk) begin
    if (rst) since_ref_q <= SAT;
    else     since_ref_q <= (since_now == SAT) ? SAT : since_now + 1'b1;
  end

  // A feedback edge is clean at once if a reference edge lay close
  // behind it; otherwise the judgement waits for a reference edge ahead.
  always_comb begin
    v_d    = '0;
    pend_d = pend_q;
    wait_d = wait_q;
    if (fb_rise) begin
      pend_d = 1'b0;
      if (since_now <= window) begin
        v_d.valid = 1'b1;
      end else if (window == '0) begin
        v_d.valid = 1'b1;
        v_d.err   = 1'b1;
      end else begin
        pend_d = 1'b1;
        wait_d = {{(WIN_W-1){1'b0}}, 1'b1};
      end
    end else if (pend_q) begin
      if (ref_rise) begin
        v_d.valid = 1'b1;
        pend_d    = 1'b0;
      end else if (wait_q >= window) begin
        v_d.valid = 1'b1;
        v_d.err   = 1'b1;
        pend_d    = 1'b0;
      end else begin
        wait_d = wait_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      wait_q  <= '0;
      verdict <= '0;
    end else begin
      pend_q  <= pend_d;
      wait_q  <= wait_d;
      verdict <= v_d;
    end
  end

  // R2: an error is never declared right after a reference edge.
  p_err_no_ref_r2: assert property (@(posedge clk) disable iff (rst)
    (verdict.valid && verdict.err) |-> !$past(ref_rise))
    else $error("R2 error verdict follows a reference edge");
endmodule

// File: rtl/lk_lock_fsm.sv
module lk_lock_fsm
  import pll_lock_pkg::*;
#(
  parameter int GAIN_CYCLES = 32,
  parameter int DROP_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  verdict_t verdict,
  input  logic     wd_fire,
  output logic     lock
);
  localparam int GW = $clog2(GAIN_CYCLES + 1);
  localparam int DW = $clog2(DROP_CYCLES + 1);

  lock_state_e   state_q;
  logic [GW-1:0] good_q;
  logic [DW-1:0] bad_q;

  always_ff @(posedge clk) begin
    if (rst || wd_fire) begin
      state_q <= ST_ACQUIRE;
      good_q  <= '0;
      bad_q   <= '0;
    end else if (verdict.valid) begin
      case (state_q)
        ST_ACQUIRE: begin
          if (verdict.err) begin
            good_q <= '0;
          end else if (good_q == GW'(GAIN_CYCLES - 1)) begin
            state_q <= ST_LOCKED;
            good_q  <= '0;
            bad_q   <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
        default: begin
          if (!verdict.err) begin
            bad_q <= '0;
          end else if (bad_q == DW'(DROP_CYCLES - 1)) begin
            state_q <= ST_ACQUIRE;
            good_q  <= '0;
            bad_q   <= '0;
          end else begin
            bad_q <= bad_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign lock = (state_q == ST_LOCKED);

  // R3: acquisition completes only on a clean judgement.
  p_rise_on_clean_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(verdict.valid && !verdict.err))
    else $error("R3 lock rose without a clean judgement");

  // R5 / R7: loss of lock needs an error judgement or a watchdog expiry.
  p_fall_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(lock) |-> $past((verdict.valid && verdict.err) || wd_fire))
    else $error("R5 lock fell without cause");

  // R9: no judgement and no expiry means no change.
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!verdict.valid && !wd_fire) |=> $stable(lock))
    else $error("R9 lock moved without an event");
endmodule

// File: rtl/lk_watchdog.sv
module lk_watchdog #(
  parameter int REF_DIV = 8,
  parameter int WD_W    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_rise,
  input  logic            fb_rise,
  input  logic            locked,
  input  logic [WD_W-1:0] limit,
  output logic            fire
);
  localparam int DVW = $clog2(REF_DIV + 1);

  logic [DVW-1:0]  div_q;
  logic [WD_W-1:0] wd_q;
  logic [WD_W:0]   wd_next;

  assign wd_next = {1'b0, wd_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || fb_rise || !locked) begin
      div_q <= '0;
      wd_q  <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (ref_rise) begin
        if (div_q == DVW'(REF_DIV - 1)) begin
          div_q <= '0;
          fire  <= (wd_next >= {1'b0, limit});
          if (wd_q != '1) wd_q <= wd_q + 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  // R7: the watchdog only expires out of the locked state.
  p_fire_locked_r7: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(locked))
    else $error("R7 watchdog fired while acquiring");

  // R8: a feedback edge always restarts the timeout.
  p_fb_restarts_r8: assert property (@(posedge clk) disable iff (rst)
    fire |-> !$past(fb_rise))
    else $error("R8 watchdog fired just after a feedback edge");
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pll_lock_pkg::*;
#(
  parameter int WIN_W       = 8,
  parameter int WD_W        = 8,
  parameter int REF_DIV     = 8,
  parameter int GAIN_CYCLES = 32,
  parameter int DROP_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_clk_in,
  input  logic             fb_clk_in,
  input  logic [WIN_W-1:0] phase_window,
  input  logic [WD_W-1:0]  wd_ticks,
  output logic             lock
);
  localparam int N_IN = 2;  // index 0: reference, 1: feedback

  logic [N_IN-1:0] raw_in, rise;
  verdict_t        verdict;
  logic            wd_fire;

  assign raw_in = {fb_clk_in, ref_clk_in};

  // R10: identical synchronizers keep the two paths matched.
  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    lk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (raw_in[i]),
      .rise     (rise[i])
    );
  end

  lk_phase_meter #(.WIN_W(WIN_W)) u_meter (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[0]),
    .fb_rise  (rise[1]),
    .window   (phase_window),
    .verdict  (verdict)
  );

  lk_lock_fsm #(
    .GAIN_CYCLES (GAIN_CYCLES),
    .DROP_CYCLES (DROP_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .verdict (verdict),
    .wd_fire (wd_fire),
    .lock    (lock)
  );

  lk_watchdog #(
    .REF_DIV (REF_DIV),
    .WD_W    (WD_W)
  ) u_wd (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[0]),
    .fb_rise  (rise[1]),
    .locked   (lock),
    .limit    (wd_ticks),
    .fire     (wd_fire)
  );
endmodule

// File: tb/pll_lock_detect_tb.sv
module pll_lock_detect_tb;
  localparam int PER = 16;  // clk ticks per reference period
  localparam int NV  = 7;

  // {fb offset after ref edge, window, expected lock after a long run}
  localparam int VEC [0:NV-1][0:2] = '{
    '{0, 0, 1},   // coincident edges
    '{3, 2, 0},   // lag 3 beyond window 2
    '{3, 3, 1},   // lag equal to window
    '{14, 2, 1},  // lead 2 within window
    '{13, 2, 0},  // lead 3 beyond window
    '{8, 7, 0},   // half period, both sides too far
    '{1, 5, 1}    // small lag, wide window
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_clk_in = 1'b0;
  logic       fb_clk_in = 1'b0;
  logic [7:0] phase_window = 8'd2;
  logic [7:0] wd_ticks = 8'd3;
  logic       lock;

  int checks = 0;
  int failures = 0;
  int phase = 0;
  int fb_off = 2;
  bit fb_en = 1'b1;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pll_lock_detect u_dut (
    .clk          (clk),
    .rst          (rst),
    .ref_clk_in   (ref_clk_in),
    .fb_clk_in    (fb_clk_in),
    .phase_window (phase_window),
    .wd_ticks     (wd_ticks),
    .lock         (lock)
  );

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_clk_in = (phase < PER / 2);
      fb_clk_in  = fb_en && (((phase + PER - fb_off) % PER) < PER / 2);
      phase      = (phase + 1) % PER;
    end
  endtask

  task automatic check(input logic exp, input string tag);
    checks++;
    if (lock !== exp) begin
      failures++;
      $display("FAIL %s lock actual=%b expected=%b", tag, lock, exp);
    end
  endtask

  // Consume n periods, checking at phase 12 of the last one.
  task automatic chk_at(input int n, input logic exp, input string tag);
    run_cycles(PER * (n - 1) + 12);
    check(exp, tag);
    run_cycles(4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ref_clk_in = 1'b0;
    fb_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = 0;
  endtask

  initial begin
    // R1: reset state
    do_reset();
    check(1'b0, "R1 after reset");
    fb_en = 1'b1;

    // R2: window judgement over a table of phase patterns
    for (int v = 0; v < NV; v++) begin
      do_reset();
      fb_off = VEC[v][0];
      phase_window = 8'(VEC[v][1]);
      run_cycles(PER * 40);
      check(VEC[v][2] != 0, $sformatf("R2 vector %0d", v));
    end

    // R1: reset while locked (last vector ended locked)
    do_reset();
    run_cycles(2);
    check(1'b0, "R1 reset clears lock");

    // R3: exactly 32 clean edges to lock
    do_reset();
    fb_off = 2;
    phase_window = 8'd2;
    chk_at(31, 1'b0, "R3 after 31 clean");
    chk_at(1, 1'b1, "R3 after 32 clean");

    // R4: an error restarts acquisition
    do_reset();
    run_cycles(PER * 20);
    phase_window = 8'd1;
    run_cycles(PER);
    phase_window = 8'd2;
    chk_at(31, 1'b0, "R4 31 clean after error");
    chk_at(1, 1'b1, "R4 32 clean after error");

    // R5: four consecutive errors drop lock
    phase_window = 8'd1;
    chk_at(3, 1'b1, "R5 after 3 errors");
    chk_at(1, 1'b0, "R5 after 4 errors");

    // R6: a clean edge clears the error run
    phase_window = 8'd2;
    chk_at(32, 1'b1, "R6 relock");
    phase_window = 8'd1;
    chk_at(3, 1'b1, "R6 first 3 errors");
    phase_window = 8'd2;
    chk_at(1, 1'b1, "R6 clean edge");
    phase_window = 8'd1;
    chk_at(3, 1'b1, "R6 3 errors after clean");
    chk_at(1, 1'b0, "R6 4th consecutive error");

    // R8: running feedback never trips the watchdog
    phase_window = 8'd2;
    wd_ticks = 8'd3;
    chk_at(32, 1'b1, "R8 relock");
    chk_at(40, 1'b1, "R8 long run with feedback");

    // R7: feedback stops; expiry on the 24th reference edge
    fb_en = 1'b0;
    chk_at(23, 1'b1, "R7 after 23 ref edges");
    chk_at(1, 1'b0, "R7 after 24 ref edges");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout lock actual=%b expected=done", lock);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule